// File: doc/BRIEF.md
# Byte-Lane Write Decode and Data Bus Direction Control

This block sits between the address stage and the storage array of a 32-bit synchronous memory that shares one set of data pins for reads and writes. Each clock edge it samples the cycle kind from the address stage and the write controls. The write controls are a global write, a byte-write enable and one select per byte lane, all active low. From them it produces a registered per-lane write mask and a write-commit flag. Both hold for the cycle that follows the sampling edge.

The same logic decides whether the shared data pins may drive read data. Any write forces the pins to float. The active-low output enable gates driving with no clock in the path. The first read after an idle or sleep cycle keeps the pins floating. After a write, the pins stay floating through suspend cycles until a new start or advance cycle arrives. Read data is flow-through from the array, so driving applies in the same cycle the access is registered.

The cycle kind uses this encoding: 0 idle (deselected), 1 processor-strobe start, 2 controller-strobe start, 3 continue (advance), 4 suspend, 5 sleep. Any other value is treated as idle.

Top module: `sram_wr_dir_ctrl`

## Requirements
- R1: With gw_n low at an edge where the cycle kind is 2, 3 or 4, wr_mask is 4'b1111 in the next cycle, whatever bwe_n and bsel_n are.
- R2: With gw_n high and bwe_n low in a kind 2, 3 or 4 cycle, wr_mask bit i is the inverse of bsel_n bit i. Bit 0 is the lane for data bits 7:0, and bit 3 is the lane for data bits 31:24.
- R3: With gw_n high and either bwe_n high or all four bsel_n bits high, the cycle is a read: wr_mask is 0 and wr_commit is 0.
- R4: An edge with kind 1 (processor start) gives wr_mask 0 in the next cycle, even when the write inputs are asserted.
- R5: A controller-start cycle (kind 2) with write inputs asserted writes on that same edge: the mask and commit appear in the cycle that follows it.
- R6: In any cycle whose wr_mask is nonzero, drive_en is 0, even for a single-lane write and even with oe_n low.
- R7: oe_n high forces drive_en to 0 within the same cycle, with no clock edge needed. oe_n low lets a driving read cycle drive.
- R8: The first read cycle registered right after an idle or sleep cycle has drive_en 0 even with oe_n low. The read cycle after it drives.
- R9: After a write cycle, drive_en stays 0 through read suspend cycles (kind 4). It returns at the next read cycle of kind 1, 2 or 3.
- R10: A cycle registered with kind 0 or 5 has drive_en 0 and wr_mask 0.
- R11: While rst_n is low at an edge, the outputs in the next cycle are 0. The first cycle after reset counts as following an idle cycle.
- R12: wr_commit is 1 exactly in the cycles whose wr_mask is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kind_i | input | 3 | Registered cycle kind from the address stage |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | 4 | Per-lane byte selects, active low, bit 0 = data bits 7:0 |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wr_mask | output | 4 | Per-lane write strobes for the current cycle |
| wr_commit | output | 1 | High while the current cycle writes the array |
| drive_en | output | 1 | High when the shared data pins drive read data |

## Verification
A corrupted lane decode shows at wr_mask one cycle after the sampling edge: a wrong lane is enabled, or a write leaks through on a processor start. A stale tracker flag shows as drive_en staying low when a read should drive, or driving too early. That happens on the first read after idle, or on the first suspend after a write, and it appears in the very cycle the flag governs. A break in the output-enable gating shows at once when oe_n toggles in the middle of a cycle.

// File: rtl/sram_ctl_pkg.sv
// Package: shared cycle-kind encoding and small helpers for the
// write-decode / bus-direction block. Assumes the address stage sends
// the 3-bit kind codes listed below; unknown codes act as idle.
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        CK_IDLE   = 3'd0,
        CK_PSTART = 3'd1,
        CK_CSTART = 3'd2,
        CK_CONT   = 3'd3,
        CK_SUSP   = 3'd4,
        CK_SLEEP  = 3'd5
    } cyc_kind_e;

    // True for kinds in which the write inputs are honoured.
    function automatic logic kind_can_write(input logic [2:0] k);
        return (k == CK_CSTART) || (k == CK_CONT) || (k == CK_SUSP);
    endfunction

    // True for kinds that perform an access (read or write).
    function automatic logic kind_active(input logic [2:0] k);
        return (k == CK_PSTART) || kind_can_write(k);
    endfunction

    // True for kinds that start an access or advance one; these release
    // a bus held floating after a write.
    function automatic logic kind_releases(input logic [2:0] k);
        return (k == CK_PSTART) || (k == CK_CSTART) || (k == CK_CONT);
    endfunction

endpackage

// File: rtl/lane_wr_decode.sv
// Module: lane_wr_decode
// Turns global write, byte-write enable and per-lane selects into a
// per-lane write mask. Purely combinational. Assumes the caller
// qualifies the result with the cycle kind through allow_i.
module lane_wr_decode #(
    parameter int LANES = 4
) (
    input  logic             allow_i,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bsel_n,
    output logic [LANES-1:0] mask_o
);

    generate
        for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
            // Per-lane strobe: global write wins, else byte enable and select.
            always_comb begin
                if (!allow_i)
                    mask_o[ln] = 1'b0;
                else if (!gw_n)
                    mask_o[ln] = 1'b1;
                else
                    mask_o[ln] = !bwe_n && !bsel_n[ln];
            end
        end
    endgenerate

endmodule

// File: rtl/cycle_tracker.sv
// Module: cycle_tracker
// Keeps the per-cycle history that bus direction depends on: whether
// the current cycle is a read, whether it is the first read after an
// idle or sleep cycle, and whether a write has parked the bus through
// suspend cycles. Assumes wr_now_i is the decoded write of the cycle
// being registered on this edge.
module cycle_tracker
    import sram_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] kind_i,
    input  logic       wr_now_i,
    output logic       rd_cycle_o,
    output logic       rd_first_o,
    output logic       rd_parked_o
);

    logic cur_idle;
    logic cur_wr;
    logic nxt_rd;
    logic nxt_park;

    // Next-state terms for read and park flags.
    always_comb begin
        nxt_rd   = kind_active(kind_i) && !wr_now_i;
        nxt_park = (kind_i == CK_SUSP) && !wr_now_i && (cur_wr || rd_parked_o);
    end

    // History registers; reset leaves the block as if after an idle cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_idle    <= 1'b1;
            cur_wr      <= 1'b0;
            rd_cycle_o  <= 1'b0;
            rd_first_o  <= 1'b0;
            rd_parked_o <= 1'b0;
        end else begin
            cur_idle    <= !kind_active(kind_i);
            cur_wr      <= wr_now_i;
            rd_cycle_o  <= nxt_rd;
            rd_first_o  <= nxt_rd && cur_idle;
            rd_parked_o <= nxt_park;
        end
    end

    // First-read flag only follows an idle or sleep cycle.
    AST_FIRST_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_first_o |-> ($past(cur_idle) || !$past(rst_n)))
        else $error("first-read flag without preceding idle"); // R8

    // Park only appears in suspend cycles.
    AST_PARK_ONLY_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(kind_i != CK_SUSP) |-> !rd_parked_o)
        else $error("bus parked outside a suspend cycle"); // R9

endmodule

// File: rtl/drive_ctrl.sv
// Module: drive_ctrl
// Combines the registered read state with the asynchronous output
// enable to decide whether the shared data pins drive. Combinational;
// assumes oe_n arrives unsynchronised and must act within the cycle.
module drive_ctrl #(
    parameter int LANES = 4
) (
    input  logic             rd_cycle_i,
    input  logic             rd_first_i,
    input  logic             rd_parked_i,
    input  logic [LANES-1:0] wr_mask_i,
    input  logic             oe_n,
    output logic             drive_en_o
);

    // Drive only on a plain read with output enable low and no write lane.
    always_comb begin
        drive_en_o = rd_cycle_i && !rd_first_i && !rd_parked_i
                     && (wr_mask_i == '0) && !oe_n;
    end

endmodule

// File: rtl/sram_wr_dir_ctrl.sv
// Module: sram_wr_dir_ctrl (top)
// Byte-lane write decode and data bus direction control for a 32-bit
// common-I/O synchronous memory. Samples cycle kind and write controls
// on each rising edge; the registered mask and commit hold for the
// following cycle, in which flow-through read data may be driven.
// Assumes kind_i is already registered by the address stage.
module sram_wr_dir_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       kind_i,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bsel_n,
    input  logic             oe_n,
    output logic [LANES-1:0] wr_mask,
    output logic             wr_commit,
    output logic             drive_en
);

    logic [LANES-1:0] mask_next;
    logic             wr_now;
    logic             allow_wr;
    logic             rd_cycle;
    logic             rd_first;
    logic             rd_parked;

    // Writes are honoured only in controller start, continue and suspend.
    always_comb begin
        allow_wr = kind_can_write(kind_i);
        wr_now   = |mask_next;
    end

    lane_wr_decode #(.LANES(LANES)) i_decode (
        .allow_i (allow_wr),
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .bsel_n  (bsel_n),
        .mask_o  (mask_next)
    );

    cycle_tracker i_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .kind_i      (kind_i),
        .wr_now_i    (wr_now),
        .rd_cycle_o  (rd_cycle),
        .rd_first_o  (rd_first),
        .rd_parked_o (rd_parked)
    );

    // Register the lane mask and commit flag for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_mask   <= '0;
            wr_commit <= 1'b0;
        end else begin
            wr_mask   <= mask_next;
            wr_commit <= wr_now;
        end
    end

    drive_ctrl #(.LANES(LANES)) i_drive (
        .rd_cycle_i  (rd_cycle),
        .rd_first_i  (rd_first),
        .rd_parked_i (rd_parked),
        .wr_mask_i   (wr_mask),
        .oe_n        (oe_n),
        .drive_en_o  (drive_en)
    );

    AST_GW_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(!gw_n && kind_can_write(kind_i)) |-> (&wr_mask))
        else $error("global write did not enable all lanes"); // R1

    AST_PSTART_READS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(kind_i == CK_PSTART) |-> (wr_mask == '0))
        else $error("write on processor start"); // R4

    AST_WRITE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> !drive_en)
        else $error("pins driven during write"); // R6

    AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !drive_en)
        else $error("drive with output enable high"); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!kind_active(kind_i)) |-> (!drive_en && wr_mask == '0))
        else $error("activity in idle or sleep cycle"); // R10

    AST_COMMIT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> (wr_mask != '0))
        else $error("commit without lanes"); // R12

endmodule

// File: tb/test_sram_wr_dir_ctrl.sv
`timescale 1ns/1ps
module test_sram_wr_dir_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] kind_i = 3'd0;
    logic       gw_n = 1'b1;
    logic       bwe_n = 1'b1;
    logic [3:0] bsel_n = 4'hF;
    logic       oe_n = 1'b1;
    logic [3:0] wr_mask;
    logic       wr_commit;
    logic       drive_en;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    logic [3:0] q_mask[$];
    logic       q_commit[$];
    logic       q_drive[$];
    string      q_tag[$];

    always #2 clk = ~clk;

    sram_wr_dir_ctrl i_sram_wr_dir_ctrl (
        .clk(clk), .rst_n(rst_n), .kind_i(kind_i), .gw_n(gw_n), .bwe_n(bwe_n),
        .bsel_n(bsel_n), .oe_n(oe_n), .wr_mask(wr_mask), .wr_commit(wr_commit),
        .drive_en(drive_en)
    );

    // Driver: drive one cycle of inputs and queue the expected outputs.
    task automatic apply(input logic r, input logic [2:0] k, input logic g,
                         input logic b, input logic [3:0] s, input logic o,
                         input logic [3:0] em, input logic ec, input logic ed,
                         input string tag);
        @(negedge clk);
        rst_n = r; kind_i = k; gw_n = g; bwe_n = b; bsel_n = s; oe_n = o;
        q_mask.push_back(em); q_commit.push_back(ec);
        q_drive.push_back(ed); q_tag.push_back(tag);
    endtask

    // Monitor: compare outputs just after the edge that registered them.
    always @(posedge clk) begin
        #1;
        if (q_mask.size() > 0) begin
            logic [3:0] em;
            logic ec, ed;
            string t;
            em = q_mask.pop_front(); ec = q_commit.pop_front();
            ed = q_drive.pop_front(); t = q_tag.pop_front();
            vectors++;
            if (wr_mask !== em || wr_commit !== ec || drive_en !== ed) begin
                fails++;
                $display("FAIL %s: mask/commit/drive got %b/%b/%b expected %b/%b/%b",
                         t, wr_mask, wr_commit, drive_en, em, ec, ed);
            end
        end
    end

    // Direct mid-cycle check of drive_en.
    task automatic check_drive(input logic ed, input string tag);
        vectors++;
        if (drive_en !== ed) begin
            fails++;
            $display("FAIL %s: drive got %b expected %b", tag, drive_en, ed);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        #20000;
        fails++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        finish_run();
    end

    initial begin
        // rst, kind, gw, bwe, bsel, oe  -> mask, commit, drive
        apply(0, 3'd3, 0, 0, 4'h0, 0, 4'h0, 0, 0, "R11 reset");
        apply(0, 3'd3, 0, 0, 4'h0, 0, 4'h0, 0, 0, "R11 reset");
        apply(1, 3'd2, 1, 1, 4'hF, 0, 4'h0, 0, 0, "R11 first read after reset");
        apply(1, 3'd0, 1, 1, 4'hF, 0, 4'h0, 0, 0, "R10 idle");
        apply(1, 3'd1, 0, 0, 4'h0, 0, 4'h0, 0, 0, "R4 R8 pstart ignores write");
        apply(1, 3'd3, 1, 1, 4'hF, 0, 4'h0, 0, 1, "R8 second read drives");
        apply(1, 3'd3, 1, 1, 4'hF, 1, 4'h0, 0, 0, "R7 oe high");
        apply(1, 3'd3, 0, 1, 4'hF, 0, 4'hF, 1, 0, "R1 R6 global write");
        apply(1, 3'd4, 1, 1, 4'hF, 0, 4'h0, 0, 0, "R9 suspend after write");
        apply(1, 3'd4, 1, 1, 4'hF, 0, 4'h0, 0, 0, "R9 suspend still parked");
        apply(1, 3'd3, 1, 1, 4'hF, 0, 4'h0, 0, 1, "R9 continue releases");
        apply(1, 3'd4, 1, 1, 4'hF, 0, 4'h0, 0, 1, "R9 suspend after read drives");
        apply(1, 3'd3, 1, 0, 4'hA, 0, 4'h5, 1, 0, "R2 R6 partial write");
        apply(1, 3'd3, 1, 0, 4'hF, 0, 4'h0, 0, 1, "R3 bwe low no selects");
        apply(1, 3'd3, 1, 1, 4'h0, 0, 4'h0, 0, 1, "R3 bwe high");
        apply(1, 3'd2, 1, 0, 4'h7, 0, 4'h8, 1, 0, "R5 R2 cstart write lane 3");
        apply(1, 3'd1, 1, 1, 4'hF, 0, 4'h0, 0, 1, "R9 pstart after write");
        apply(1, 3'd5, 0, 0, 4'h0, 0, 4'h0, 0, 0, "R10 sleep");
        apply(1, 3'd2, 1, 1, 4'hF, 0, 4'h0, 0, 0, "R8 first read after sleep");
        apply(1, 3'd4, 1, 1, 4'hF, 0, 4'h0, 0, 1, "R8 next read drives");
        apply(1, 3'd2, 0, 1, 4'hF, 0, 4'hF, 1, 0, "R1 R5 cstart global write");
        apply(1, 3'd4, 1, 0, 4'hE, 0, 4'h1, 1, 0, "R2 R12 suspend write lane 0");
        apply(1, 3'd4, 1, 0, 4'hF, 0, 4'h0, 0, 0, "R12 R9 suspend read parked");
        apply(1, 3'd3, 1, 1, 4'hF, 0, 4'h0, 0, 1, "R7 read before oe toggle");
        // Asynchronous output enable inside the cycle just registered.
        @(posedge clk);
        #1.2 oe_n = 1'b1;
        #0.3 check_drive(1'b0, "R7 oe high mid-cycle");
        oe_n = 1'b0;
        #0.2 check_drive(1'b1, "R7 oe low mid-cycle");
        apply(1, 3'd0, 0, 0, 4'h0, 0, 4'h0, 0, 0, "R10 idle ignores write");
        apply(0, 3'd3, 0, 1, 4'hF, 0, 4'h0, 0, 0, "R11 reset mid-run");
        apply(1, 3'd3, 1, 1, 4'hF, 0, 4'h0, 0, 0, "R11 first read after reset");
        repeat (3) @(posedge clk);
        #2;
        finish_run();
    end

endmodule